// File: doc/BRIEF.md
# Dual-Compare Timer with Half-Cycle Output Placement

This block is an up-counting timer that turns two compare values into a periodic rectangular wave. While counting is enabled, the counter steps once per rising clock edge and returns to zero after it has held the compare-B value. The period is therefore B + 1 clocks. The wave output becomes active on the clock edge that moves the counter past compare A. It goes back to inactive on the edge that returns the counter to zero. Each of these two events also sets a sticky interrupt flag, which stays set until its own clear strobe removes it.

The output polarity can be selected. Output enable is separate from counting, so the pin can be parked at a defined off level while the counter keeps running. In fine-placement mode the compare-A match drops the low bit of compare A and matches against the counter one bit lower. That low bit then chooses the switching edge: 0 keeps the output switching on the rising edge, and 1 moves the whole output waveform half a clock later, onto the falling edge. The configuration is held in simple write-enabled registers. A value written takes effect at the rising edge where its strobe is sampled.

The output path is a three-state machine with these states:
- WV_OFF: output disabled.
- WV_IDLE: enabled and inactive.
- WV_ACTIVE: enabled and active.

It has these transitions:
- OFF→IDLE when the output enable is set.
- IDLE→ACTIVE on a compare-A event.
- ACTIVE→IDLE on a compare-B event.
- IDLE→OFF and ACTIVE→OFF when the output enable is cleared.

Top module: `dcmp_timer`

## Requirements
- R1: A synchronous reset makes the counter 0 and both flags 0. It returns every configuration register to 0 (stopped, output disabled, polarity 0, fine mode off, both compares 0). The pin therefore reads low.
- R2: While counting is enabled, each rising edge adds one to the counter. At the edge where the counter equals compare B, it becomes 0 instead, giving a period of B + 1 clocks.
- R3: With counting disabled, the counter holds its value and no compare event occurs.
- R4: With output enabled and default placement, the output is active exactly while the counter shows a value greater than A and at most B. With A = 3 and B = 5 it is active on counts 4 and 5.
- R5: If the effective compare-A value is not less than B, the output never becomes active and the compare-A flag is never set.
- R6: With polarity 0 the pin equals the active level. With polarity 1 the pin is the inverse (active low, idle high).
- R7: While the output enable is 0 the pin sits at the off level, which is low for polarity 0 and high for polarity 1. After the output is re-enabled it stays inactive until the next compare-A event.
- R8: In fine mode the compare-A match compares counter bits [W-2:0] with A[W-1:0] shifted right by one. When A bit 0 is 0, the output still switches on rising edges.
- R9: In fine mode with A bit 0 set to 1, every pin transition occurs on the falling edge half a clock after the rising edge where it would otherwise occur.
- R10: The compare-A flag is set in the cycle the counter first shows A_eff + 1. The compare-B flag is set in the cycle the counter returns to 0 from B. Both flags stay set until cleared.
- R11: Each flag is cleared by its own clear strobe. When a set and a clear of the same flag coincide, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Write strobe for the four control bits below |
| run_d | input | 1 | Count enable value |
| oe_d | input | 1 | Output enable value |
| pol_d | input | 1 | Polarity value: 0 active high, 1 active low |
| fine_d | input | 1 | Fine-placement mode value |
| cmpa_we | input | 1 | Write strobe for compare A |
| cmpa_d | input | CNT_W | Compare A value |
| cmpb_we | input | 1 | Write strobe for compare B |
| cmpb_d | input | CNT_W | Compare B value |
| irq_a_clr | input | 1 | Clear strobe for the compare-A flag |
| irq_b_clr | input | 1 | Clear strobe for the compare-B flag |
| tmr_pin | output | 1 | Timer wave output |
| tmr_count | output | CNT_W | Current counter value |
| irq_a | output | 1 | Sticky compare-A flag |
| irq_b | output | 1 | Sticky compare-B flag |

## Verification
The bench builds the timer with CNT_W = 8 and FINE_SUPPORT = 1. The narrow counter brings a compare B at the very top of the range, and the resulting full-range period, within a few hundred cycles. Keeping the fine-placement variant elaborated lets both edge choices of the output stage be observed. Samples are taken one quarter and three quarters of a period after each rising edge, so a falling-edge transition shows up as a difference between the two samples of one cycle.

// File: rtl/dcmp_timer_pkg.sv
package dcmp_timer_pkg;

    typedef enum logic [1:0] {
        WV_OFF    = 2'd0,
        WV_IDLE   = 2'd1,
        WV_ACTIVE = 2'd2
    } wave_state_e;

    typedef struct packed {
        logic run;
        logic oe;
        logic pol;
        logic fine;
    } tmr_ctrl_t;

    localparam int IRQ_N = 2;
    localparam int IRQ_A = 0;
    localparam int IRQ_B = 1;

endpackage

// File: rtl/dcmp_cfg_regs.sv
module dcmp_cfg_regs
    import dcmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  tmr_ctrl_t        ctrl_d,
    input  logic             cmpa_we,
    input  logic [CNT_W-1:0] cmpa_d,
    input  logic             cmpb_we,
    input  logic [CNT_W-1:0] cmpb_d,
    output tmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] cmpa_q,
    output logic [CNT_W-1:0] cmpb_q
);

    // Control bits: one strobe updates all four fields together.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmpa_q <= '0;
        end else if (cmpa_we) begin
            cmpa_q <= cmpa_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmpb_q <= '0;
        end else if (cmpb_we) begin
            cmpb_q <= cmpb_d;
        end
    end

endmodule

// File: rtl/dcmp_count_unit.sv
module dcmp_count_unit #(
    parameter int CNT_W        = 16,
    parameter bit FINE_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fine,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    output logic [CNT_W-1:0] cnt,
    output logic             ev_a,
    output logic             ev_b
);

    localparam int HALF_W = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic             hit_a;
    logic             at_top;
    logic             below_b;

    // The compare-A match has two forms. The fine form drops bit 0 of the
    // compare value and matches it one counter bit lower.
    generate
        if (FINE_SUPPORT) begin : g_fine_cmp
            always_comb begin
                if (fine) begin
                    hit_a = (cnt_q[HALF_W-1:0] == cmpa[CNT_W-1:1]);
                end else begin
                    hit_a = (cnt_q == cmpa);
                end
            end
        end else begin : g_plain_cmp
            always_comb hit_a = (cnt_q == cmpa);
        end
    endgenerate

    always_comb begin
        at_top  = (cnt_q == cmpb);
        below_b = (cnt_q < cmpb);
        ev_b    = run & at_top;
        // A match at or past B would never leave a visible active window.
        ev_a    = run & hit_a & below_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run) begin
            if (at_top) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/dcmp_wave_fsm.sv
module dcmp_wave_fsm
    import dcmp_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        oe,
    input  logic        ev_a,
    input  logic        ev_b,
    output wave_state_e state,
    output logic        lvl_rise
);

    wave_state_e st_q;
    wave_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WV_OFF: begin
                if (oe) st_d = WV_IDLE;
            end
            WV_IDLE: begin
                if (!oe)       st_d = WV_OFF;
                else if (ev_a) st_d = WV_ACTIVE;
            end
            WV_ACTIVE: begin
                if (!oe)       st_d = WV_OFF;
                else if (ev_b) st_d = WV_IDLE;
            end
            default: st_d = WV_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WV_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (st_q)
            WV_ACTIVE: lvl_rise = 1'b1;
            WV_IDLE:   lvl_rise = 1'b0;
            WV_OFF:    lvl_rise = 1'b0;
            default:   lvl_rise = 1'b0;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/dcmp_half_edge.sv
module dcmp_half_edge #(
    parameter bit FINE_SUPPORT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_rise,
    input  logic half_sel,
    input  logic pol,
    output logic pin
);

    generate
        if (FINE_SUPPORT) begin : g_half
            logic neg_q;

            // Copy of the rising-edge level, taken half a clock later.
            always_ff @(negedge clk) begin
                if (rst) begin
                    neg_q <= 1'b0;
                end else begin
                    neg_q <= lvl_rise;
                end
            end

            always_comb pin = (half_sel ? neg_q : lvl_rise) ^ pol;
        end else begin : g_direct
            always_comb pin = lvl_rise ^ pol;
        end
    endgenerate

endmodule

// File: rtl/dcmp_irq_flags.sv
module dcmp_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            logic f_q;

            // A set that coincides with a clear takes priority.
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q <= 1'b0;
                end else if (set[i]) begin
                    f_q <= 1'b1;
                end else if (clr[i]) begin
                    f_q <= 1'b0;
                end
            end

            assign flag[i] = f_q;
        end
    endgenerate

endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
    import dcmp_timer_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter bit FINE_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             run_d,
    input  logic             oe_d,
    input  logic             pol_d,
    input  logic             fine_d,
    input  logic             cmpa_we,
    input  logic [CNT_W-1:0] cmpa_d,
    input  logic             cmpb_we,
    input  logic [CNT_W-1:0] cmpb_d,
    input  logic             irq_a_clr,
    input  logic             irq_b_clr,
    output logic             tmr_pin,
    output logic [CNT_W-1:0] tmr_count,
    output logic             irq_a,
    output logic             irq_b
);

    tmr_ctrl_t        ctrl_d;
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cmpa_q;
    logic [CNT_W-1:0] cmpb_q;
    logic             ev_a;
    logic             ev_b;
    wave_state_e      wave_st;
    logic             lvl_rise;
    logic             half_sel;
    logic [IRQ_N-1:0] irq_set;
    logic [IRQ_N-1:0] irq_clr;
    logic [IRQ_N-1:0] irq_flag;

    always_comb begin
        ctrl_d.run  = run_d;
        ctrl_d.oe   = oe_d;
        ctrl_d.pol  = pol_d;
        ctrl_d.fine = fine_d;
    end

    dcmp_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (ctrl_we),
        .ctrl_d  (ctrl_d),
        .cmpa_we (cmpa_we),
        .cmpa_d  (cmpa_d),
        .cmpb_we (cmpb_we),
        .cmpb_d  (cmpb_d),
        .ctrl_q  (ctrl_q),
        .cmpa_q  (cmpa_q),
        .cmpb_q  (cmpb_q)
    );

    dcmp_count_unit #(.CNT_W(CNT_W), .FINE_SUPPORT(FINE_SUPPORT)) u_count (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .fine (ctrl_q.fine),
        .cmpa (cmpa_q),
        .cmpb (cmpb_q),
        .cnt  (tmr_count),
        .ev_a (ev_a),
        .ev_b (ev_b)
    );

    dcmp_wave_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .oe       (ctrl_q.oe),
        .ev_a     (ev_a),
        .ev_b     (ev_b),
        .state    (wave_st),
        .lvl_rise (lvl_rise)
    );

    // The select only changes on a configuration write, never at a compare
    // event, so switching between the two paths does not glitch the pin.
    assign half_sel = ctrl_q.fine & cmpa_q[0];

    dcmp_half_edge #(.FINE_SUPPORT(FINE_SUPPORT)) u_half (
        .clk      (clk),
        .rst      (rst),
        .lvl_rise (lvl_rise),
        .half_sel (half_sel),
        .pol      (ctrl_q.pol),
        .pin      (tmr_pin)
    );

    always_comb begin
        irq_set[IRQ_A] = ev_a;
        irq_set[IRQ_B] = ev_b;
        irq_clr[IRQ_A] = irq_a_clr;
        irq_clr[IRQ_B] = irq_b_clr;
    end

    dcmp_irq_flags #(.N(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (irq_set),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign irq_a = irq_flag[IRQ_A];
    assign irq_b = irq_flag[IRQ_B];

endmodule

// File: rtl/dcmp_timer_chk.sv
module dcmp_timer_chk
    import dcmp_timer_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter bit FINE_SUPPORT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             run_q,
    input logic             oe_q,
    input logic             pol_q,
    input logic             fine_q,
    input logic [CNT_W-1:0] cmpa_q,
    input logic [CNT_W-1:0] cmpb_q,
    input logic [CNT_W-1:0] cnt,
    input wave_state_e      state,
    input logic             irq_a,
    input logic             irq_b,
    input logic             irq_a_clr,
    input logic             irq_b_clr,
    input logic             pin
);

    logic [CNT_W-1:0] a_eff;

    always_comb begin
        if (FINE_SUPPORT && fine_q) begin
            a_eff = {1'b0, cmpa_q[CNT_W-1:1]};
        end else begin
            a_eff = cmpa_q;
        end
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt == cmpb_q) |=> (cnt == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt != cmpb_q) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(cnt));

    a_r5_no_edge: assert property (@(posedge clk) disable iff (rst)
        (state == WV_IDLE && a_eff >= cmpb_q) |=> (state != WV_ACTIVE));

    a_r6_active_pin: assert property (@(posedge clk) disable iff (rst)
        (state == WV_ACTIVE && $past(state) == WV_ACTIVE) |-> (pin == !pol_q));

    a_r7_off_level: assert property (@(posedge clk) disable iff (rst)
        (state == WV_OFF && $past(state) == WV_OFF) |-> (pin == pol_q));

    a_r7_enter_off: assert property (@(posedge clk) disable iff (rst)
        !oe_q |=> (state == WV_OFF));

    a_r10_flag_b: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt == cmpb_q) |=> irq_b);

    a_r10_flag_a_src: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_a) |-> $past(run_q));

    a_r11_hold_a: assert property (@(posedge clk) disable iff (rst)
        (irq_a && !irq_a_clr) |=> irq_a);

    a_r11_hold_b: assert property (@(posedge clk) disable iff (rst)
        (irq_b && !irq_b_clr) |=> irq_b);

endmodule

bind dcmp_timer dcmp_timer_chk #(
    .CNT_W        (CNT_W),
    .FINE_SUPPORT (FINE_SUPPORT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_q     (ctrl_q.run),
    .oe_q      (ctrl_q.oe),
    .pol_q     (ctrl_q.pol),
    .fine_q    (ctrl_q.fine),
    .cmpa_q    (cmpa_q),
    .cmpb_q    (cmpb_q),
    .cnt       (tmr_count),
    .state     (wave_st),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .irq_a_clr (irq_a_clr),
    .irq_b_clr (irq_b_clr),
    .pin       (tmr_pin)
);

// File: tb/dcmp_timer_bench.sv
module dcmp_timer_bench;

    localparam int W  = 8;
    localparam int NV = 9;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         pol;
        logic         fine;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'd3,   8'd5,   1'b0, 1'b0},
        '{8'd3,   8'd5,   1'b1, 1'b0},
        '{8'd7,   8'd9,   1'b0, 1'b1},
        '{8'd6,   8'd9,   1'b1, 1'b1},
        '{8'd5,   8'd5,   1'b0, 1'b0},
        '{8'd0,   8'd1,   1'b0, 1'b0},
        '{8'd0,   8'd0,   1'b1, 1'b0},
        '{8'd9,   8'd4,   1'b0, 1'b1},
        '{8'd250, 8'd255, 1'b0, 1'b0}
    };

    logic         clk;
    logic         rst;
    logic         ctrl_we, run_d, oe_d, pol_d, fine_d;
    logic         cmpa_we, cmpb_we;
    logic [W-1:0] cmpa_d, cmpb_d;
    logic         irq_a_clr, irq_b_clr;
    logic         tmr_pin;
    logic [W-1:0] tmr_count;
    logic         irq_a, irq_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Requirement model state.
    logic         m_run, m_fine;
    logic [W-1:0] m_cnt, m_a, m_b;
    logic         m_irqa, m_irqb;
    logic         s_early, s_late;

    dcmp_timer #(.CNT_W(W), .FINE_SUPPORT(1'b1)) u_dcmp_timer (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .run_d     (run_d),
        .oe_d      (oe_d),
        .pol_d     (pol_d),
        .fine_d    (fine_d),
        .cmpa_we   (cmpa_we),
        .cmpa_d    (cmpa_d),
        .cmpb_we   (cmpb_we),
        .cmpb_d    (cmpb_d),
        .irq_a_clr (irq_a_clr),
        .irq_b_clr (irq_b_clr),
        .tmr_pin   (tmr_pin),
        .tmr_count (tmr_count),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] eff_a(input logic [W-1:0] a, input logic fine);
        return fine ? (a >> 1) : a;
    endfunction

    // One clock: model the edge, sample before and after the falling edge.
    task automatic tick();
        logic [W-1:0] ae;
        logic         eva, evb;
        @(posedge clk);
        if (rst) begin
            m_run = 0; m_fine = 0; m_cnt = '0; m_a = '0; m_b = '0;
            m_irqa = 0; m_irqb = 0;
        end else begin
            ae  = eff_a(m_a, m_fine);
            eva = m_run && (m_cnt == ae) && (m_cnt < m_b);
            evb = m_run && (m_cnt == m_b);
            if (m_run) m_cnt = evb ? '0 : m_cnt + 1'b1;
            m_irqa = eva | (m_irqa & ~irq_a_clr);
            m_irqb = evb | (m_irqb & ~irq_b_clr);
            if (ctrl_we) begin m_run = run_d; m_fine = fine_d; end
            if (cmpa_we) m_a = cmpa_d;
            if (cmpb_we) m_b = cmpb_d;
        end
        #1;
        s_early = tmr_pin;
        #2;
        s_late = tmr_pin;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic write_ctrl(input logic run, input logic oe, input logic pol, input logic fine);
        ctrl_we = 1'b1; run_d = run; oe_d = oe; pol_d = pol; fine_d = fine;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic setup(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic pol, input logic fine);
        cmpa_we = 1'b1; cmpa_d = a; cmpb_we = 1'b1; cmpb_d = b;
        write_ctrl(1'b0, 1'b1, pol, fine);
        cmpa_we = 1'b0; cmpb_we = 1'b0;
        tick();
        tick();
        write_ctrl(1'b1, 1'b1, pol, fine);
    endtask

    initial begin
        rst = 1'b1;
        ctrl_we = 0; run_d = 0; oe_d = 0; pol_d = 0; fine_d = 0;
        cmpa_we = 0; cmpb_we = 0; cmpa_d = '0; cmpb_d = '0;
        irq_a_clr = 0; irq_b_clr = 0;
        do_reset();

        // R1: reset state.
        check("R1 count after reset", int'(tmr_count), 0);
        check("R1 pin after reset", int'(s_late), 0);
        check("R1 irq_a after reset", int'(irq_a), 0);
        check("R1 irq_b after reset", int'(irq_b), 0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            vec_t         vc;
            logic [W-1:0] ae;
            logic         half, lvl, lvl_prev;
            string        tg;
            int           ncyc;
            vc   = VECS[v];
            ae   = eff_a(vc.a, vc.fine);
            half = vc.fine & vc.a[0];
            if (ae >= vc.b)           tg = "R5";
            else if (half)            tg = "R9";
            else if (vc.fine)         tg = "R8";
            else if (vc.pol)          tg = "R6";
            else                      tg = "R4";
            ncyc = 2 * (int'(vc.b) + 1) + 4;
            do_reset();
            setup(vc.a, vc.b, vc.pol, vc.fine);
            lvl_prev = 1'b0;
            for (int c = 0; c < ncyc; c++) begin
                tick();
                lvl = (ae < vc.b) && (m_cnt > ae) && (m_cnt <= vc.b);
                check("R2 counter", int'(tmr_count), int'(m_cnt));
                check({tg, " pin early"}, int'(s_early),
                      int'(vc.pol ^ (half ? lvl_prev : lvl)));
                check({tg, " pin late"}, int'(s_late), int'(vc.pol ^ lvl));
                check("R10 irq_a", int'(irq_a), int'(m_irqa));
                check("R10 irq_b", int'(irq_b), int'(m_irqb));
                lvl_prev = lvl;
            end
        end

        // R1: synchronous reset while running.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 count after running reset", int'(tmr_count), 0);
        check("R1 irq_a after running reset", int'(irq_a), 0);
        check("R1 irq_b after running reset", int'(irq_b), 0);
        check("R1 pin after running reset", int'(s_late), 0);

        // R7: off level follows polarity while disabled.
        write_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 off level high for polarity 1", int'(s_early), 1);
        tick();
        check("R7 off level stays high", int'(s_late), 1);

        // R7: stop mid-active, then re-enable.
        do_reset();
        setup(8'd2, 8'd9, 1'b0, 1'b0);
        for (int k = 0; k < 20 && tmr_count != 8'd5; k++) tick();
        check("R4 active at count 5", int'(s_late), 1);
        write_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        check("R7 pin off after disable", int'(s_late), 0);
        tick();
        check("R7 pin stays off", int'(s_late), 0);
        write_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        begin
            bit seen0;
            seen0 = 0;
            for (int k = 0; k < 25; k++) begin
                tick();
                if (tmr_count == 0) seen0 = 1;
                check("R7 waits for next compare-A", int'(s_late),
                      int'(seen0 && tmr_count > 8'd2 && tmr_count <= 8'd9));
            end
        end

        // R3: freeze.
        write_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        begin
            logic [W-1:0] held;
            held = tmr_count;
            for (int k = 0; k < 4; k++) begin
                tick();
                check("R3 counter frozen", int'(tmr_count), int'(held));
            end
        end

        // R11: clear strobes and set-over-clear priority.
        do_reset();
        setup(8'd3, 8'd5, 1'b0, 1'b0);
        for (int k = 0; k < 30 && !(tmr_count == 8'd1 && irq_a); k++) tick();
        irq_a_clr = 1'b1;
        tick();
        irq_a_clr = 1'b0;
        check("R11 irq_a cleared", int'(irq_a), 0);
        tick();
        check("R10 irq_a not yet set at count 3", int'(irq_a), 0);
        irq_a_clr = 1'b1;
        tick();
        irq_a_clr = 1'b0;
        check("R11 set wins over clear (a) count", int'(tmr_count), 4);
        check("R11 set wins over clear (a)", int'(irq_a), 1);
        for (int k = 0; k < 10 && tmr_count != 8'd5; k++) tick();
        irq_b_clr = 1'b1;
        tick();
        check("R11 set wins over clear (b)", int'(irq_b), 1);
        tick();
        irq_b_clr = 1'b0;
        check("R11 irq_b cleared", int'(irq_b), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule